// File: doc/BRIEF.md
# Halt-Aware Imprecise Abort Deferral

This block sits between the memory system's asynchronous error reporting and the core's exception entry logic. It holds at most one imprecise (asynchronous) data abort, together with a 4-bit type code, and asks the core to take it only when the core is running and the abort mask bit is clear. While the core is halted for debugging, an abort is never taken.

Around a debug halt the block tracks whether the debugger's first memory barrier has completed. Aborts that drain out before that barrier completes are captured in the single pending slot and are delivered after the core resumes. Aborts that arrive after the barrier has completed only raise a sticky indication that the debugger clears by reading status. Such aborts are otherwise dropped and never replace the captured one. The fault log write strobe fires only when the core actually accepts an abort, so halted-time aborts never touch the fault status or fault address registers.

Top module: `dbg_abort_defer`

## Requirements
- R1: `take_req_o` is high exactly when an abort is pending, `amask_i` is 0 and `halted_i` is 0. It is combinational on those inputs.
- R2: `drain_done_o` is 0 on the first halted cycle. One cycle after a `barrier_done_i` pulse seen while halted, it reads 1 and then holds for the rest of the halt. A barrier pulse seen while running has no effect.
- R3: `drain_done_o` reads 0 one cycle after a cycle in which `halted_i` is 0.
- R4: An abort reported while halted with `drain_done_o` = 0 sets `sticky_abort_o` on the next cycle. If nothing is pending, it also loads the pending slot with its type. It raises no `take_req_o` while halted.
- R5: An abort reported while halted with `drain_done_o` = 1 sets `sticky_abort_o`. It leaves `pend_o` and `pend_type_o` unchanged.
- R6: A pending abort raises `take_req_o` on the first running cycle after a halt if `amask_i` is 0. While `amask_i` is 1 the abort stays pending and is requested once the mask clears.
- R7: A `status_rd_i` strobe clears `sticky_abort_o` on the next cycle and leaves the pending slot untouched. A halted abort in the same cycle wins, so the bit stays 1.
- R8: `flog_we_o` is high exactly in a cycle where `take_req_o` and `take_ack_i` are both 1, with `flog_type_o` equal to the pending type. It is never high while halted.
- R9: Acceptance (`take_req_o` and `take_ack_i`) clears `pend_o` on the next cycle. An abort reported in that same cycle, and allowed to latch, reloads the slot instead.
- R10: An abort and a `barrier_done_i` pulse in the same halted cycle, with `drain_done_o` = 0, latch the abort. `drain_done_o` rises on the next cycle.
- R11: An abort reported while running loads the empty slot without touching `sticky_abort_o`. If an abort is already pending, the first one's type is kept.
- R12: After synchronous reset, `pend_o`, `pend_type_o`, `drain_done_o`, `sticky_abort_o`, `take_req_o` and `flog_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halted_i | input | 1 | Core is in debug halt |
| abort_vld_i | input | 1 | Imprecise abort reported this cycle |
| abort_type_i | input | TYPE_W | Type code of the reported abort |
| barrier_done_i | input | 1 | Memory barrier has drained all outstanding accesses |
| amask_i | input | 1 | Asynchronous abort mask bit of the program status |
| status_rd_i | input | 1 | Debug status register is being read |
| take_ack_i | input | 1 | Core accepts the abort request this cycle |
| take_req_o | output | 1 | Request to take the pending imprecise abort |
| pend_o | output | 1 | An abort is held in the pending slot |
| pend_type_o | output | TYPE_W | Type code of the held abort |
| drain_done_o | output | 1 | Status bit: first barrier of this halt completed |
| sticky_abort_o | output | 1 | Status bit: imprecise abort seen while halted |
| flog_we_o | output | 1 | Write strobe for the fault status and address registers |
| flog_type_o | output | TYPE_W | Type code written to the fault log |

## Verification
The properties assume that every input is known at each rising edge. They also assume that `take_ack_i` has meaning only in a cycle where it is paired with `take_req_o`, since the block ignores it otherwise. The assertions make no assumption about the order in which halts, barriers and aborts occur. For that reason the stimulus deliberately includes barrier pulses while running, repeated barriers while halted, acknowledges without a request, and status reads colliding with aborts. The random phase keeps `halted_i` at a level for many cycles at a time, so that both early and late halted aborts occur in long stretches.

// File: rtl/abt_pkg.sv
// Package: shared types for the halt-aware imprecise abort deferral block.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package abt_pkg;

    // Action taken on the pending slot in one cycle.
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_CLEAR = 2'd2
    } slot_act_e;

    // Decide the pending-slot action from the qualified load and accept terms.
    function automatic slot_act_e slot_action(input logic load, input logic accept);
        if (load)        return SLOT_LOAD;
        else if (accept) return SLOT_CLEAR;
        else             return SLOT_HOLD;
    endfunction

endpackage

// File: rtl/abt_drain_track.sv
// Module: abt_drain_track
// Tracks whether the first memory barrier after a debug halt has completed.
// Assumes halted_i is a level that is low whenever the core is running; the
// flag is held at 0 while running so it always reads 0 on halt entry.
module abt_drain_track (
    input  logic clk,
    input  logic rst_n,
    input  logic halted_i,
    input  logic barrier_done_i,
    output logic drain_done_o
);

    logic drain_q;
    logic drain_d;

    // Next-state: set by a barrier while halted, held while halted, cleared when running.
    always_comb begin
        if (!halted_i)
            drain_d = 1'b0;
        else if (barrier_done_i)
            drain_d = 1'b1;
        else
            drain_d = drain_q;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_q <= 1'b0;
        else
            drain_q <= drain_d;
    end

    assign drain_done_o = drain_q;

endmodule

// File: rtl/abt_sticky.sv
// Module: abt_sticky
// Holds the sticky "imprecise abort while halted" status bit.
// Assumes set_i and clr_i are single-cycle qualified strobes. SET_WINS picks
// which strobe dominates when both arrive in one cycle.
module abt_sticky #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sticky_o
);

    logic sticky_q;
    logic sticky_d;

    generate
        if (SET_WINS) begin : g_set_wins
            // Next-state: a new event survives a clearing read in the same cycle.
            always_comb begin
                if (set_i)
                    sticky_d = 1'b1;
                else if (clr_i)
                    sticky_d = 1'b0;
                else
                    sticky_d = sticky_q;
            end
        end else begin : g_clr_wins
            // Next-state: a clearing read dominates a same-cycle event.
            always_comb begin
                if (clr_i)
                    sticky_d = 1'b0;
                else if (set_i)
                    sticky_d = 1'b1;
                else
                    sticky_d = sticky_q;
            end
        end
    endgenerate

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= 1'b0;
        else
            sticky_q <= sticky_d;
    end

    assign sticky_o = sticky_q;

endmodule

// File: rtl/abt_pend_latch.sv
// Module: abt_pend_latch
// Single pending-abort slot: a valid flag and the abort's type code.
// Assumes the caller has already qualified the load (allowed window) and accept
// (request and acknowledge both high). A load in an accept cycle reloads.
module abt_pend_latch
    import abt_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok_i,
    input  logic [TYPE_W-1:0] load_type_i,
    input  logic              accept_i,
    output logic              pend_o,
    output logic [TYPE_W-1:0] type_o
);

    logic              pend_q;
    logic [TYPE_W-1:0] type_q;
    logic              load;
    slot_act_e         act;

    // Load only into an empty slot or one being emptied this cycle.
    always_comb begin
        load = load_ok_i && (!pend_q || accept_i);
        act  = slot_action(load, accept_i);
    end

    // Slot register: valid flag and type, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            type_q <= '0;
        end else begin
            case (act)
                SLOT_LOAD: begin
                    pend_q <= 1'b1;
                    type_q <= load_type_i;
                end
                SLOT_CLEAR: pend_q <= 1'b0;
                default:    pend_q <= pend_q;
            endcase
        end
    end

    assign pend_o = pend_q;
    assign type_o = type_q;

endmodule

// File: rtl/abt_take_ctl.sv
// Module: abt_take_ctl
// Forms the take request and the fault-log write strobe.
// Assumes the core samples take_req_o and answers with take_ack_i in the same
// cycle; an acknowledge without a request is ignored.
module abt_take_ctl #(
    parameter int TYPE_W = 4
) (
    input  logic              pend_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic              halted_i,
    input  logic              amask_i,
    input  logic              take_ack_i,
    output logic              take_req_o,
    output logic              accept_o,
    output logic              flog_we_o,
    output logic [TYPE_W-1:0] flog_type_o
);

    // Request only when pending, unmasked and running; log only on acceptance.
    always_comb begin
        take_req_o  = pend_i && !amask_i && !halted_i;
        accept_o    = take_req_o && take_ack_i;
        flog_we_o   = accept_o;
        flog_type_o = accept_o ? type_i : '0;
    end

endmodule

// File: rtl/dbg_abort_defer.sv
// Module: dbg_abort_defer (top)
// Latches, defers and delivers imprecise data aborts around a debug halt.
// Assumes all inputs are synchronous to clk; barrier_done_i is a pulse, the
// other controls are levels or strobes sampled at each rising edge.
module dbg_abort_defer #(
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted_i,
    input  logic              abort_vld_i,
    input  logic [TYPE_W-1:0] abort_type_i,
    input  logic              barrier_done_i,
    input  logic              amask_i,
    input  logic              status_rd_i,
    input  logic              take_ack_i,
    output logic              take_req_o,
    output logic              pend_o,
    output logic [TYPE_W-1:0] pend_type_o,
    output logic              drain_done_o,
    output logic              sticky_abort_o,
    output logic              flog_we_o,
    output logic [TYPE_W-1:0] flog_type_o
);

    logic drain;
    logic accept;
    logic load_window;
    logic load_ok;
    logic sticky_set;

    // Barrier-complete status flag for the current halt.
    abt_drain_track u_drain (
        .clk            (clk),
        .rst_n          (rst_n),
        .halted_i       (halted_i),
        .barrier_done_i (barrier_done_i),
        .drain_done_o   (drain)
    );

    // Qualify aborts: latch when running or before the first barrier of a halt.
    always_comb begin
        load_window = !halted_i || !drain;
        load_ok     = abort_vld_i && load_window;
        sticky_set  = abort_vld_i && halted_i;
    end

    // Pending slot.
    abt_pend_latch #(.TYPE_W(TYPE_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_ok_i   (load_ok),
        .load_type_i (abort_type_i),
        .accept_i    (accept),
        .pend_o      (pend_o),
        .type_o      (pend_type_o)
    );

    // Sticky halted-abort status bit.
    abt_sticky #(.SET_WINS(1'b1)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (sticky_set),
        .clr_i    (status_rd_i),
        .sticky_o (sticky_abort_o)
    );

    // Request and fault-log generation.
    abt_take_ctl #(.TYPE_W(TYPE_W)) u_take (
        .pend_i      (pend_o),
        .type_i      (pend_type_o),
        .halted_i    (halted_i),
        .amask_i     (amask_i),
        .take_ack_i  (take_ack_i),
        .take_req_o  (take_req_o),
        .accept_o    (accept),
        .flog_we_o   (flog_we_o),
        .flog_type_o (flog_type_o)
    );

    assign drain_done_o = drain;

endmodule

// File: rtl/dbg_abort_defer_chk.sv
// Module: dbg_abort_defer_chk
// Property checker for dbg_abort_defer, attached through bind below.
// Assumes inputs are known at every rising edge after reset.
module dbg_abort_defer_chk #(
    parameter int TYPE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted_i,
    input logic              abort_vld_i,
    input logic              barrier_done_i,
    input logic              status_rd_i,
    input logic              take_ack_i,
    input logic              take_req_o,
    input logic              pend_o,
    input logic [TYPE_W-1:0] pend_type_o,
    input logic              drain_done_o,
    input logic              sticky_abort_o,
    input logic              flog_we_o
);

    AST_NO_TAKE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |-> !take_req_o); // R1

    AST_DRAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i && barrier_done_i |=> drain_done_o); // R2

    AST_DRAIN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !halted_i |=> !drain_done_o); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i && abort_vld_i |=> sticky_abort_o); // R4

    AST_LATE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i && drain_done_o && pend_o |=> pend_o && $stable(pend_type_o)); // R5

    AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd_i && !(halted_i && abort_vld_i) |=> !sticky_abort_o); // R7

    AST_NO_LOG_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |-> !flog_we_o); // R8

    AST_ACCEPT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o && take_ack_i && !abort_vld_i |=> !pend_o); // R9

endmodule

bind dbg_abort_defer dbg_abort_defer_chk #(.TYPE_W(TYPE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .halted_i       (halted_i),
    .abort_vld_i    (abort_vld_i),
    .barrier_done_i (barrier_done_i),
    .status_rd_i    (status_rd_i),
    .take_ack_i     (take_ack_i),
    .take_req_o     (take_req_o),
    .pend_o         (pend_o),
    .pend_type_o    (pend_type_o),
    .drain_done_o   (drain_done_o),
    .sticky_abort_o (sticky_abort_o),
    .flog_we_o      (flog_we_o)
);

// File: tb/sim_dbg_abort_defer.sv
module sim_dbg_abort_defer;

    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halted = 1'b0;
    logic          abt = 1'b0;
    logic [TW-1:0] abt_ty = '0;
    logic          bar = 1'b0;
    logic          amask = 1'b0;
    logic          rd = 1'b0;
    logic          ack = 1'b0;
    logic          take_req, pend, drain, sticky, flog_we;
    logic [TW-1:0] pend_ty, flog_ty;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_pend = 0, m_type = 0, m_drain = 0, m_sticky = 0;

    always #10 clk = ~clk;

    dbg_abort_defer #(.TYPE_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .halted_i(halted), .abort_vld_i(abt),
        .abort_type_i(abt_ty), .barrier_done_i(bar), .amask_i(amask),
        .status_rd_i(rd), .take_ack_i(ack), .take_req_o(take_req),
        .pend_o(pend), .pend_type_o(pend_ty), .drain_done_o(drain),
        .sticky_abort_o(sticky), .flog_we_o(flog_we), .flog_type_o(flog_ty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare every output against the reference for the current inputs.
    task automatic cmp_all();
        int e_take;
        e_take = (m_pend != 0 && !amask && !halted) ? 1 : 0;
        chk("R1 take_req", int'(take_req), e_take);
        chk("R2 drain_done", int'(drain), m_drain);
        chk("R4 sticky", int'(sticky), m_sticky);
        chk("R9 pend", int'(pend), m_pend);
        if (m_pend != 0) chk("R5 pend_type", int'(pend_ty), m_type);
        chk("R8 flog_we", int'(flog_we), (e_take != 0 && ack) ? 1 : 0);
        if (e_take != 0 && ack) chk("R8 flog_type", int'(flog_ty), m_type);
    endtask

    // Reference update at a rising edge.
    task automatic model_edge();
        int take, acc, allow, load;
        take  = (m_pend != 0 && !amask && !halted) ? 1 : 0;
        acc   = (take != 0 && ack) ? 1 : 0;
        allow = (!halted || m_drain == 0) ? 1 : 0;
        load  = (abt && allow != 0 && (m_pend == 0 || acc != 0)) ? 1 : 0;
        if (load != 0) begin
            m_pend = 1;
            m_type = int'(abt_ty);
        end else if (acc != 0) begin
            m_pend = 0;
        end
        m_sticky = (halted && abt) ? 1 : (rd ? 0 : m_sticky);
        m_drain  = !halted ? 0 : ((bar || m_drain != 0) ? 1 : 0);
    endtask

    // Drive one cycle of inputs, compare, then clock it.
    task automatic step(input logic h, input logic a, input int t, input logic b,
                        input logic m, input logic r, input logic k);
        halted = h; abt = a; abt_ty = TW'(t); bar = b; amask = m; rd = r; ack = k;
        #1;
        cmp_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input logic h, input logic m);
        step(h, 1'b0, 0, 1'b0, m, 1'b0, 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset pend", int'(pend), 0);
        chk("R12 reset drain", int'(drain), 0);
        chk("R12 reset sticky", int'(sticky), 0);
        chk("R12 reset take", int'(take_req), 0);
        chk("R12 reset flog", int'(flog_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: running aborts with mask set, first one kept, no sticky
        step(0, 1, 3, 0, 1, 0, 0);
        step(0, 1, 7, 0, 1, 0, 0);
        chk("R11 first type kept", int'(pend_ty), 3);
        chk("R11 no sticky", int'(sticky), 0);
        // R1 / R8 / R9: unmask then accept
        idle(0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        #1;
        chk("R9 cleared after accept", int'(pend), 0);

        // R2: barrier while running ignored, zero on halt entry
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R2 running barrier ignored", int'(drain), 0);
        idle(1, 0);
        chk("R2 drain zero in halt", int'(drain), 0);

        // R10: abort and barrier same cycle while halted
        step(1, 1, 5, 1, 0, 0, 0);
        chk("R10 latched", int'(pend), 1);
        chk("R10 type", int'(pend_ty), 5);
        chk("R10 drain rose", int'(drain), 1);
        chk("R4 sticky set", int'(sticky), 1);
        // R7: read clears sticky only
        step(1, 0, 0, 0, 0, 1, 0);
        chk("R7 sticky cleared", int'(sticky), 0);
        chk("R7 pend kept", int'(pend), 1);
        // R5: late abort only sticky
        step(1, 1, 9, 0, 0, 0, 0);
        chk("R5 type kept", int'(pend_ty), 5);
        chk("R5 sticky", int'(sticky), 1);
        // R7: read with same-cycle abort keeps sticky
        step(1, 1, 2, 0, 0, 1, 0);
        chk("R7 set wins", int'(sticky), 1);
        step(1, 0, 0, 0, 0, 1, 1);
        chk("R8 no take while halted", int'(pend), 1);
        // R3 / R6: exit with mask set, then clear
        idle(0, 1);
        chk("R3 drain cleared", int'(drain), 0);
        chk("R6 held while masked", int'(take_req), 0);
        halted = 0; amask = 0; #1;
        chk("R6 requested after exit", int'(take_req), 1);
        step(0, 0, 0, 0, 0, 0, 1);

        // R4: halted early abort with slot occupied keeps old type
        step(0, 1, 4, 0, 1, 0, 0);
        step(1, 1, 6, 0, 1, 0, 0);
        chk("R4 occupied slot kept", int'(pend_ty), 4);
        idle(0, 0);
        // R9: accept with new abort reloads
        step(0, 1, 12, 0, 0, 0, 1);
        chk("R9 reload pend", int'(pend), 1);
        chk("R9 reload type", int'(pend_ty), 12);
        step(0, 0, 0, 0, 0, 0, 1);

        // Random phase compared every cycle
        for (int i = 0; i < 4000; i++) begin
            if ((i % 37) == 0) halted = ~halted;
            step(halted, ($urandom % 4) == 0, int'($urandom % 16),
                 ($urandom % 8) == 0, ($urandom % 3) == 0,
                 ($urandom % 6) == 0, ($urandom % 2) == 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule